// File: doc/BRIEF.md
# Bit-Serial Rotate-AND-XOR Feistel Block Cipher

This block encrypts one block of a lightweight two-word Feistel cipher. Its datapath is one bit wide. Each clock it computes one bit of one round. A round over n-bit words therefore takes n clocks. The two block words and the four key words sit in shift registers that shift least significant bit first.

The round function is f(x) = (x AND rotl(x,5)) XOR rotl(x,1). One 1-bit slice evaluates it for the data path, and an identical slice evaluates it for the key schedule. Each slice takes its rotated bits from the same register position. A two-input multiplexer per rotation amount then chooses whether that bit still lies in the word being updated or has already moved into the neighbouring register. A small LFSR supplies one constant bit per round.

The block is used as a serial peripheral. A start pulse opens a load phase, in which key and plaintext arrive one bit per clock. The rounds then run without further input. The ciphertext leaves one bit per clock, and a done pulse flags its first bit.

Top module: `simeck_ser_top`

## Requirements
- R1: While and right after reset, `busy`, `ct_valid` and `done` are 0.
- R2: A `start` sampled while idle opens a load phase of KEY_WORDS*WORD clocks. In load clock i, `key_in` carries key bit i, where key bit 0 is the least significant bit of key word 0. In load clock i < 2*WORD, `pt_in` carries plaintext bit i; the plaintext is {left word, right word}. `pt_in` is ignored in the remaining load clocks.
- R3: One round maps (L,R,K) to (R XOR f(L) XOR K, L), with K taken from key word 0. After every round the key words move down one place (word i takes word i+1). The top word becomes w0 XOR f(w1) XOR c. The constant c has all bits 1 except bit 1, which is 0, and bit 0, which is the current LFSR output.
- R4: The LFSR starts all ones at each start and steps once per round. Its sequence obeys s(i+W) = s(i+TAP) XOR s(i). With the defaults, key 64'h1918111009080100 and plaintext 32'h65656877 give ciphertext 32'h770d2c76.
- R5: The first ciphertext bit appears exactly (KEY_WORDS+ROUNDS)*WORD clocks after the clock that samples `start`. `busy` stays high for (KEY_WORDS+ROUNDS+2)*WORD clocks in total.
- R6: `ct_valid` is high for exactly 2*WORD consecutive clocks. `ct_out` carries ciphertext bit 0 first (the right word, LSB first), followed by the left word.
- R7: `done` is high for one clock only, the clock of the first ciphertext bit.
- R8: A `start` that arrives while `busy` is high has no effect on the result or on the timing.
- R9: `ct_valid` is high only while `busy` is high, and `busy` drops after the last ciphertext bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a load phase when idle |
| pt_in | input | 1 | Serial plaintext bit |
| key_in | input | 1 | Serial key bit |
| busy | output | 1 | A load, run or output phase is in progress |
| ct_out | output | 1 | Serial ciphertext bit |
| ct_valid | output | 1 | `ct_out` holds a ciphertext bit |
| done | output | 1 | Marks the first ciphertext bit |

## Verification
The bench builds the block with its defaults: 16-bit words, 32 rounds, four key words, and a 5-bit LFSR tapped at position 2. At this size a whole encryption takes 608 clocks, so dozens of random blocks fit in the run. The fixed known-answer vector then covers the constant pattern, the LFSR phase and every wrap-around multiplexer switch in all 32 rounds. The two rotation selects switch at bit offsets 1 and 5 of a 16-bit word, so both sides of each multiplexer are used in every round.

// File: rtl/simeck_ser_pkg.sv
// Shared types and fixed rotation amounts of the serial cipher.
// Assumes the word width exceeds the larger rotation amount.
package simeck_ser_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2,
        PH_OUT  = 2'd3
    } phase_t;

    localparam int ROT_AND = 5;
    localparam int ROT_XOR = 1;

endpackage

// File: rtl/simeck_ser_slice.sv
// One-bit slice of f(x) = (x & rotl(x,RA)) ^ rotl(x,RX), plus the two XOR terms.
// "cur" is the word being rewritten and "nxt" is the register that receives its
// shifted-out bits. A rotated bit lives at position N-r of cur during the first
// r clocks of a round, and at position N-r of nxt after that.
module simeck_ser_slice (
    input  logic cur_lo,
    input  logic cur_ra,
    input  logic cur_rx,
    input  logic nxt_lo,
    input  logic nxt_ra,
    input  logic nxt_rx,
    input  logic sel_ra,
    input  logic sel_rx,
    input  logic inj,
    output logic nbit
);

    logic tap_ra;
    logic tap_rx;

    // wrap-around selection for each rotation amount
    always_comb begin
        tap_ra = sel_ra ? cur_ra : nxt_ra;
        tap_rx = sel_rx ? cur_rx : nxt_rx;
    end

    // new bit of the updated word
    assign nbit = (cur_lo & tap_ra) ^ tap_rx ^ nxt_lo ^ inj;

endmodule

// File: rtl/simeck_ser_lfsr.sv
// Fibonacci LFSR that supplies one round-constant bit per round.
// Output is st[0]; the recurrence is s(i+LW) = s(i+TAP) ^ s(i). Reloads to all ones.
module simeck_ser_lfsr #(
    parameter int LW  = 5,
    parameter int TAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    output logic zbit
);

    logic [LW-1:0] st;

    // hold, reload or advance the sequence register
    always_ff @(posedge clk) begin
        if (!rst_n || init) st <= '1;
        else if (step)      st <= {st[TAP] ^ st[0], st[LW-1:1]};
    end

    assign zbit = st[0];

endmodule

// File: rtl/simeck_ser_ctrl.sv
// Phase sequencer: bit counter modulo N plus a segment counter that counts words
// while loading, rounds while running, and words while unloading.
// Assumes start is a level that is sampled only while idle.
module simeck_ser_ctrl
    import simeck_ser_pkg::*;
#(
    parameter int N      = 16,
    parameter int ROUNDS = 32,
    parameter int KW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output phase_t               phase,
    output logic [$clog2(N)-1:0] bit_idx,
    output logic                 load_pt,
    output logic                 sel_ra,
    output logic                 sel_rx,
    output logic                 lfsr_init,
    output logic                 lfsr_step,
    output logic                 done
);

    localparam int BW    = $clog2(N);
    localparam int SEGS  = (ROUNDS > KW) ? ROUNDS : KW;
    localparam int SEG_W = $clog2(SEGS);

    logic [SEG_W-1:0] seg;
    logic             bit_last;
    logic             seg_last;

    // end-of-word and end-of-phase detection
    always_comb begin
        bit_last = (bit_idx == BW'(N - 1));
        case (phase)
            PH_LOAD: seg_last = (seg == SEG_W'(KW - 1));
            PH_RUN:  seg_last = (seg == SEG_W'(ROUNDS - 1));
            PH_OUT:  seg_last = (seg == SEG_W'(1));
            default: seg_last = 1'b0;
        endcase
    end

    // phase, bit and segment counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            seg     <= '0;
        end else if (phase == PH_IDLE) begin
            bit_idx <= '0;
            seg     <= '0;
            if (start) phase <= PH_LOAD;
        end else if (bit_last) begin
            bit_idx <= '0;
            if (seg_last) begin
                seg   <= '0;
                phase <= (phase == PH_LOAD) ? PH_RUN :
                         (phase == PH_RUN)  ? PH_OUT : PH_IDLE;
            end else begin
                seg <= seg + 1'b1;
            end
        end else begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // decoded controls for the datapath
    always_comb begin
        load_pt   = (phase == PH_LOAD) && (seg < SEG_W'(2));
        sel_ra    = (bit_idx < BW'(ROT_AND));
        sel_rx    = (bit_idx < BW'(ROT_XOR));
        lfsr_init = (phase == PH_IDLE) && start;
        lfsr_step = (phase == PH_RUN) && bit_last;
        done      = (phase == PH_OUT) && (seg == '0) && (bit_idx == '0);
    end

endmodule

// File: rtl/simeck_ser_top.sv
// Bit-serial encryptor of the rotate-AND-XOR Feistel cipher.
// Block words a (left) and b (right) and key words kw[0..KW-1] are right-shifting
// registers: the LSB is consumed, and the new bit enters at the MSB.
// Assumes WORD > 5 and a 64-entry-or-smaller round count.
module simeck_ser_top
    import simeck_ser_pkg::*;
#(
    parameter int WORD      = 16,
    parameter int ROUNDS    = 32,
    parameter int KEY_WORDS = 4,
    parameter int LFSR_W    = 5,
    parameter int LFSR_TAP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pt_in,
    input  logic key_in,
    output logic busy,
    output logic ct_out,
    output logic ct_valid,
    output logic done
);

    localparam int N  = WORD;
    localparam int BW = $clog2(N);

    phase_t                     phase;
    logic [BW-1:0]              bit_idx;
    logic                       load_pt, sel_ra, sel_rx, lfsr_init, lfsr_step;
    logic                       zbit, cbit, rbit, kbit;
    logic [N-1:0]               a, b;
    logic [KEY_WORDS-1:0][N-1:0] kw;
    logic                       blk_shift, key_shift;

    simeck_ser_ctrl #(.N(N), .ROUNDS(ROUNDS), .KW(KEY_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .bit_idx(bit_idx),
        .load_pt(load_pt), .sel_ra(sel_ra), .sel_rx(sel_rx),
        .lfsr_init(lfsr_init), .lfsr_step(lfsr_step), .done(done)
    );

    simeck_ser_lfsr #(.LW(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .init(lfsr_init), .step(lfsr_step), .zbit(zbit)
    );

    // round constant bit: z at bit 0, zero at bit 1, one elsewhere
    always_comb begin
        if (bit_idx == '0)              cbit = zbit;
        else if (bit_idx == BW'(1))     cbit = 1'b0;
        else                            cbit = 1'b1;
    end

    simeck_ser_slice u_round (
        .cur_lo(a[0]), .cur_ra(a[N-ROT_AND]), .cur_rx(a[N-ROT_XOR]),
        .nxt_lo(b[0]), .nxt_ra(b[N-ROT_AND]), .nxt_rx(b[N-ROT_XOR]),
        .sel_ra(sel_ra), .sel_rx(sel_rx), .inj(kw[0][0]), .nbit(rbit)
    );

    simeck_ser_slice u_keysched (
        .cur_lo(kw[1][0]), .cur_ra(kw[1][N-ROT_AND]), .cur_rx(kw[1][N-ROT_XOR]),
        .nxt_lo(kw[0][0]), .nxt_ra(kw[0][N-ROT_AND]), .nxt_rx(kw[0][N-ROT_XOR]),
        .sel_ra(sel_ra), .sel_rx(sel_rx), .inj(cbit), .nbit(kbit)
    );

    // shift enables per phase
    always_comb begin
        blk_shift = load_pt || (phase == PH_RUN) || (phase == PH_OUT);
        key_shift = (phase == PH_LOAD) || (phase == PH_RUN);
    end

    // block word registers: a takes input or round bit, b takes a's LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a <= '0;
            b <= '0;
        end else if (blk_shift) begin
            a <= {(phase == PH_LOAD) ? pt_in : ((phase == PH_RUN) ? rbit : 1'b0), a[N-1:1]};
            b <= {a[0], b[N-1:1]};
        end
    end

    // key word chain: top word takes input or schedule bit, each lower word the one above
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kw <= '0;
        end else if (key_shift) begin
            for (int i = 0; i < KEY_WORDS; i++) begin
                if (i == KEY_WORDS - 1)
                    kw[i] <= {(phase == PH_LOAD) ? key_in : kbit, kw[i][N-1:1]};
                else
                    kw[i] <= {kw[i+1][0], kw[i][N-1:1]};
            end
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign ct_valid = (phase == PH_OUT);
    assign ct_out   = b[0];

endmodule

// File: rtl/simeck_ser_chk.sv
// Protocol checker for the serial encryptor, attached by bind.
// Counts busy and valid run lengths to check the window lengths without deep $past.
module simeck_ser_chk #(
    parameter int N      = 16,
    parameter int ROUNDS = 32,
    parameter int KW     = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic ct_valid,
    input logic done
);

    localparam int unsigned BUSY_LEN  = (KW + ROUNDS + 2) * N;
    localparam int unsigned VALID_LEN = 2 * N;

    int unsigned bcnt;
    int unsigned vcnt;

    // run-length counters for busy and valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= 0;
            vcnt <= 0;
        end else begin
            bcnt <= busy ? bcnt + 1 : 0;
            vcnt <= ct_valid ? vcnt + 1 : 0;
        end
    end

    assert_done_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ct_valid);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_first_bit_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ct_valid) |-> done);
    assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> busy);
    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BUSY_LEN));
    assert_valid_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ct_valid) |-> (vcnt == VALID_LEN));

endmodule

bind simeck_ser_top simeck_ser_chk #(.N(WORD), .ROUNDS(ROUNDS), .KW(KEY_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ct_valid(ct_valid), .done(done)
);

// File: tb/simeck_ser_top_bench.sv
// Self-checking bench: reference model computed word-parallel, DUT driven serially.
module simeck_ser_top_bench;

    localparam int N      = 16;
    localparam int ROUNDS = 32;
    localparam int KW     = 4;
    localparam int LAT    = (KW + ROUNDS) * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pt_in = 1'b0;
    logic key_in = 1'b0;
    logic busy, ct_out, ct_valid, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    simeck_ser_top u_simeck_ser_top (
        .clk(clk), .rst_n(rst_n), .start(start), .pt_in(pt_in), .key_in(key_in),
        .busy(busy), .ct_out(ct_out), .ct_valid(ct_valid), .done(done)
    );

    function automatic logic [N-1:0] rotl(input logic [N-1:0] x, input int s);
        return (x << s) | (x >> (N - s));
    endfunction

    function automatic logic [N-1:0] ffun(input logic [N-1:0] x);
        return (x & rotl(x, 5)) ^ rotl(x, 1);
    endfunction

    // reference encryption per R3/R4
    function automatic logic [2*N-1:0] model(input logic [2*N-1:0] pt, input logic [KW*N-1:0] key);
        logic [N-1:0] l, r, tmp, nk;
        logic [N-1:0] t [KW];
        logic [4:0]   lf;
        l  = pt[2*N-1:N];
        r  = pt[N-1:0];
        for (int i = 0; i < KW; i++) t[i] = key[i*N +: N];
        lf = '1;
        for (int rnd = 0; rnd < ROUNDS; rnd++) begin
            tmp = l;
            l   = r ^ ffun(l) ^ t[0];
            r   = tmp;
            nk  = t[0] ^ ffun(t[1]) ^ {{(N-2){1'b1}}, 1'b0, lf[0]};
            for (int i = 0; i < KW - 1; i++) t[i] = t[i+1];
            t[KW-1] = nk;
            lf = {lf[2] ^ lf[0], lf[4:1]};
        end
        return {l, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one serial encryption; junk drives random pt_in in the key-only load clocks,
    // mid_start pulses start while busy
    task automatic run_enc(input logic [2*N-1:0] pt, input logic [KW*N-1:0] key,
                           input bit junk, input bit mid_start, input logic [2*N-1:0] exp, input string tag);
        logic [2*N-1:0] ct;
        int cnt;
        bit done_ok;
        bit valid_ok;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        for (int i = 0; i < KW*N; i++) begin
            key_in = key[i];
            pt_in  = (i < 2*N) ? pt[i] : (junk ? 1'($urandom) : 1'b0);
            @(negedge clk);
            cnt++;
        end
        while (!ct_valid && cnt < LAT + 100) begin
            start = (mid_start && cnt == KW*N + 7);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == LAT, {tag, " R5 latency"}, 64'(cnt), 64'(LAT));
        done_ok = 1;
        valid_ok = 1;
        for (int i = 0; i < 2*N; i++) begin
            ct[i] = ct_out;
            if (done !== (i == 0)) done_ok = 0;
            if (ct_valid !== 1'b1) valid_ok = 0;
            @(negedge clk);
        end
        check(ct == exp, {tag, " R3 R6 ciphertext"}, 64'(ct), 64'(exp));
        check(done_ok, {tag, " R7 done on first bit only"}, 64'(done_ok), 64'd1);
        check(valid_ok && !ct_valid, {tag, " R6 valid window"}, 64'(ct_valid), 64'd0);
        check(busy == 1'b0, {tag, " R9 busy drops"}, 64'(busy), 64'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0]  pt;
        logic [KW*N-1:0] key;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !ct_valid && !done, "R1 reset state", {61'd0, busy, ct_valid, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !ct_valid && !done, "R1 after reset", {61'd0, busy, ct_valid, done}, 64'd0);

        // R4 known answer
        run_enc(32'h65656877, 64'h1918111009080100, 0, 0, 32'h770d2c76, "R4 kat");
        // corner patterns
        run_enc('0, '0, 0, 0, model('0, '0), "R3 zeros");
        run_enc('1, '1, 0, 0, model('1, '1), "R3 ones");
        // R2: pt_in noise after plaintext words must not matter
        pt  = 32'h0123abcd;
        key = {$urandom, $urandom};
        run_enc(pt, key, 1, 0, model(pt, key), "R2 ignored pt_in");
        // R8: start while busy has no effect
        pt  = $urandom;
        key = {$urandom, $urandom};
        run_enc(pt, key, 0, 1, model(pt, key), "R8 start while busy");
        // random blocks
        for (int k = 0; k < 20; k++) begin
            pt  = $urandom;
            key = {$urandom, $urandom};
            run_enc(pt, key, k[0], 0, model(pt, key), "R3 random");
            repeat (k % 3) @(negedge clk);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule